// File: doc/BRIEF.md
# Oversampled Input Transition Timestamper

This block watches a group of gate-drive inputs with a fast sampling clock that runs many times inside each slower simulation step. A step strobe marks each step boundary. Between two strobes the block notes, for every input, whether its level changed and the sub-step tick at which the change was first seen. At each strobe it hands a per-input record to a downstream state-space solver: the level at the start of the step, the level at its end, a changed flag, the tick index and an overflow flag. The solver computes the step with the old level and uses the record to correct its state in the following step, so the corrected result arrives one step late.

Every input first crosses a synchroniser chain. The tick index is corrected for that chain's delay, so it counts clock edges after the strobe edge at which the new level was first sampled. Each input can report at most one transition per step. A later transition in the same step raises the overflow flag and leaves the first index in place. When the oversampling enable is low, the block reduces to a single comparison per step, made at the step boundary.

Top module: `edge_stamp_top`

## Requirements
- R1: A tick counter returns to zero on the clock edge that takes the strobe. It then rises by one per clock and holds at MAX_TICKS-1.
- R2: A new input level first sampled on the m-th clock edge after the strobe edge (the strobe edge is edge 0) is reported with tick index min(m, MAX_TICKS-SYNC_STAGES). A level sampled before that edge but detected after it reports index 0.
- R3: The record's old level is the synchronised level taken at the previous strobe (0 after reset). Its new level is the synchronised level at the closing strobe.
- R4: With the enable high, the changed flag is 1 exactly when at least one transition was detected during the step.
- R5: The tick index reported is the index of the first transition in the step. Later transitions in that step do not alter it.
- R6: A second or later transition on the same input within one step sets that input's overflow flag for that step's record.
- R7: A record whose changed flag is 0 carries tick index 0 and overflow 0.
- R8: Records update only on a strobe edge and stay constant between strobes. The valid output is high for exactly the one cycle after each strobe edge.
- R9: With the enable low at the strobe, changed = (new level != old level), and both the tick index and overflow are 0.
- R10: A transition detected in the strobe cycle itself belongs to the step that the strobe closes, not to the next step.
- R11: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | One-cycle step boundary strobe, synchronous to clk |
| os_en_i | input | 1 | Oversampling enable, tied high in normal use |
| raw_i | input | N_IN | Asynchronous gate-drive inputs |
| rec_valid_o | output | 1 | One-cycle pulse after each strobe |
| rec_old_o | output | N_IN | Level at the start of the closed step |
| rec_new_o | output | N_IN | Level at the end of the closed step |
| rec_chg_o | output | N_IN | Transition seen in the closed step |
| rec_ovf_o | output | N_IN | More than one transition seen |
| rec_tick_o | output | N_IN*CNT_W | Tick index per input, input k in bits [k*CNT_W +: CNT_W] |

## Verification
A step strobe and the detection of an edge can occur in the same cycle. The bench provokes this by toggling an input exactly synchroniser-latency cycles before the strobe. It also toggles inputs on the cycle right after a strobe and twice inside one step, so that a second transition meets a strobe or another pending record. A behavioural model with per-input shift queues predicts every record field on every clock. Directed checks confirm that the colliding edge is reported in the closing step and that the first index is kept when overflow is set.

// File: rtl/es_pkg.sv
package es_pkg;

   // Saturating subtract used to remove the synchroniser delay from a tick count.
   function automatic int unsigned floor_sub(input int unsigned a, input int unsigned b);
      return (a >= b) ? (a - b) : 0;
   endfunction

endpackage

// File: rtl/es_sync.sv
module es_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("es_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      chain_q[s] <= '0;
         else if (s == 0) chain_q[s] <= d_i;
         else             chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/es_tick_cnt.sv
module es_tick_cnt #(
   parameter int MAX_TICKS = 256,
   localparam int CNT_W    = $clog2(MAX_TICKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   output logic [CNT_W-1:0] cnt_o
);
   if (MAX_TICKS < 4) begin : g_bad_ticks
      $error("es_tick_cnt: MAX_TICKS must be at least 4");
   end

   localparam logic [CNT_W-1:0] TOP = CNT_W'(MAX_TICKS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_o <= '0;
      else if (step_i)       cnt_o <= '0;
      else if (cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
   end

   // R1
   cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |=> (cnt_o == '0));

   // R1
   cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && cnt_o == TOP) |=> (cnt_o == TOP));
endmodule

// File: rtl/es_channel.sv
module es_channel #(
   parameter int CNT_W      = 8,
   parameter int LAT        = 1,
   parameter bit OS_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             os_en_i,
   input  logic             lvl_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             old_o,
   output logic             new_o,
   output logic             chg_o,
   output logic             ovf_o,
   output logic [CNT_W-1:0] tick_o
);
   logic             prev_q, base_q;
   logic             seen_q, ovf_q;
   logic [CNT_W-1:0] stamp_q;
   logic             edge_w;
   logic [CNT_W-1:0] stamp_now;

   assign edge_w    = lvl_i ^ prev_q;
   assign stamp_now = CNT_W'(es_pkg::floor_sub(int'(cnt_i), LAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         base_q <= 1'b0;
      end else begin
         prev_q <= lvl_i;
         if (step_i) base_q <= lvl_i;
      end
   end

   if (OS_SUPPORT) begin : g_capture
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            seen_q  <= 1'b0;
            ovf_q   <= 1'b0;
            stamp_q <= '0;
         end else if (step_i) begin
            seen_q  <= 1'b0;
            ovf_q   <= 1'b0;
            stamp_q <= '0;
         end else if (edge_w) begin
            if (!seen_q) begin
               seen_q  <= 1'b1;
               stamp_q <= stamp_now;
            end else begin
               ovf_q   <= 1'b1;
            end
         end
      end
   end else begin : g_no_capture
      assign seen_q  = 1'b0;
      assign ovf_q   = 1'b0;
      assign stamp_q = '0;
   end

   logic             use_os;
   logic             nxt_chg, nxt_ovf;
   logic [CNT_W-1:0] nxt_tick;

   always_comb begin
      use_os = OS_SUPPORT && os_en_i;
      if (use_os) begin
         nxt_chg  = seen_q | edge_w;
         nxt_ovf  = ovf_q | (seen_q & edge_w);
         if (seen_q)      nxt_tick = stamp_q;
         else if (edge_w) nxt_tick = stamp_now;
         else             nxt_tick = '0;
      end else begin
         nxt_chg  = lvl_i ^ base_q;
         nxt_ovf  = 1'b0;
         nxt_tick = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         old_o  <= 1'b0;
         new_o  <= 1'b0;
         chg_o  <= 1'b0;
         ovf_o  <= 1'b0;
         tick_o <= '0;
      end else if (step_i) begin
         old_o  <= base_q;
         new_o  <= lvl_i;
         chg_o  <= nxt_chg;
         ovf_o  <= nxt_ovf;
         tick_o <= nxt_tick;
      end
   end

   // R6
   ovf_needs_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> chg_o);

   // R7
   idle_tick_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chg_o |-> (tick_o == '0 && !ovf_o));

   // R5
   stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && !step_i) |=> $stable(stamp_q));

   // R9
   plain_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !os_en_i) |=> (!ovf_o && tick_o == '0 && chg_o == (new_o ^ old_o)));

   // R8
   rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> ($stable(tick_o) && $stable(chg_o) && $stable(old_o) && $stable(new_o)));

   // R3
   old_from_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |=> (old_o == $past(base_q)));
endmodule

// File: rtl/edge_stamp_top.sv
module edge_stamp_top #(
   parameter int N_IN        = 4,
   parameter int MAX_TICKS   = 256,
   parameter int SYNC_STAGES = 2,
   parameter bit OS_SUPPORT  = 1'b1,
   localparam int CNT_W      = $clog2(MAX_TICKS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  step_i,
   input  logic                  os_en_i,
   input  logic [N_IN-1:0]       raw_i,
   output logic                  rec_valid_o,
   output logic [N_IN-1:0]       rec_old_o,
   output logic [N_IN-1:0]       rec_new_o,
   output logic [N_IN-1:0]       rec_chg_o,
   output logic [N_IN-1:0]       rec_ovf_o,
   output logic [N_IN*CNT_W-1:0] rec_tick_o
);
   localparam int LAT = SYNC_STAGES - 1;

   if (N_IN < 1) begin : g_bad_n
      $error("edge_stamp_top: N_IN must be at least 1");
   end
   if (MAX_TICKS <= SYNC_STAGES) begin : g_bad_ratio
      $error("edge_stamp_top: MAX_TICKS must exceed SYNC_STAGES");
   end

   logic [N_IN-1:0]  lvl_w;
   logic [CNT_W-1:0] cnt_w;

   es_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_i),
      .q_o   (lvl_w)
   );

   es_tick_cnt #(.MAX_TICKS(MAX_TICKS)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step_i),
      .cnt_o  (cnt_w)
   );

   for (genvar k = 0; k < N_IN; k++) begin : g_ch
      es_channel #(.CNT_W(CNT_W), .LAT(LAT), .OS_SUPPORT(OS_SUPPORT)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .step_i  (step_i),
         .os_en_i (os_en_i),
         .lvl_i   (lvl_w[k]),
         .cnt_i   (cnt_w),
         .old_o   (rec_old_o[k]),
         .new_o   (rec_new_o[k]),
         .chg_o   (rec_chg_o[k]),
         .ovf_o   (rec_ovf_o[k]),
         .tick_o  (rec_tick_o[k*CNT_W +: CNT_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rec_valid_o <= 1'b0;
      else        rec_valid_o <= step_i;
   end

   // R8
   valid_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |=> rec_valid_o);

   // R8
   valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> !rec_valid_o);
endmodule

// File: tb/edge_stamp_top_test.sv
module edge_stamp_top_test;
   localparam int N    = 4;
   localparam int MAXT = 32;
   localparam int SYNC = 2;
   localparam int CW   = $clog2(MAXT);
   localparam int LAT  = SYNC - 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            step_i = 1'b0;
   logic            os_en_i = 1'b1;
   logic [N-1:0]    raw_i = '0;
   logic            rec_valid_o;
   logic [N-1:0]    rec_old_o, rec_new_o, rec_chg_o, rec_ovf_o;
   logic [N*CW-1:0] rec_tick_o;

   int checks = 0;
   int errors = 0;
   bit live = 1'b0;

   always #2 clk = ~clk;

   edge_stamp_top #(.N_IN(N), .MAX_TICKS(MAXT), .SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .os_en_i(os_en_i), .raw_i(raw_i),
      .rec_valid_o(rec_valid_o), .rec_old_o(rec_old_o), .rec_new_o(rec_new_o),
      .rec_chg_o(rec_chg_o), .rec_ovf_o(rec_ovf_o), .rec_tick_o(rec_tick_o)
   );

   // Behavioural reference: per-input delay queues and step bookkeeping.
   int q_lvl [N][$];
   int m_prev [N], m_base [N], m_seen [N], m_ovf [N], m_stamp [N];
   int e_old [N], e_new [N], e_chg [N], e_ovf [N], e_tick [N];
   int m_cnt, e_valid;

   task automatic model_reset();
      for (int c = 0; c < N; c++) begin
         q_lvl[c] = {};
         for (int s = 0; s < SYNC; s++) q_lvl[c].push_back(0);
         m_prev[c] = 0; m_base[c] = 0; m_seen[c] = 0; m_ovf[c] = 0; m_stamp[c] = 0;
         e_old[c] = 0; e_new[c] = 0; e_chg[c] = 0; e_ovf[c] = 0; e_tick[c] = 0;
      end
      m_cnt = 0; e_valid = 0;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         for (int c = 0; c < N; c++) begin
            int now_lvl, edg, sn;
            now_lvl = q_lvl[c][SYNC-1];
            edg = (now_lvl != m_prev[c]);
            sn = (m_cnt >= LAT) ? m_cnt - LAT : 0;
            if (step_i) begin
               e_old[c] = m_base[c];
               e_new[c] = now_lvl;
               if (os_en_i) begin
                  e_chg[c]  = m_seen[c] | edg;
                  e_ovf[c]  = m_ovf[c] | (m_seen[c] & edg);
                  e_tick[c] = m_seen[c] ? m_stamp[c] : (edg ? sn : 0);
               end else begin
                  e_chg[c] = (now_lvl != m_base[c]);
                  e_ovf[c] = 0;
                  e_tick[c] = 0;
               end
               m_base[c] = now_lvl; m_seen[c] = 0; m_ovf[c] = 0; m_stamp[c] = 0;
            end else if (edg) begin
               if (m_seen[c] == 0) begin m_seen[c] = 1; m_stamp[c] = sn; end
               else m_ovf[c] = 1;
            end
            m_prev[c] = now_lvl;
            void'(q_lvl[c].pop_back());
            q_lvl[c].push_front(int'(raw_i[c]));
         end
         e_valid = step_i;
         if (step_i) m_cnt = 0;
         else if (m_cnt != MAXT-1) m_cnt++;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int tick_of(input int c);
      return int'(rec_tick_o[c*CW +: CW]);
   endfunction

   // Cycle-by-cycle comparison against the model, away from the active edge.
   always @(negedge clk) begin
      if (live) begin
         check("R8 valid", int'(rec_valid_o), e_valid);
         for (int c = 0; c < N; c++) begin
            check("R3 old level", int'(rec_old_o[c]), e_old[c]);
            check("R3 new level", int'(rec_new_o[c]), e_new[c]);
            check(os_en_i ? "R4 changed" : "R9 changed", int'(rec_chg_o[c]), e_chg[c]);
            check("R1 R2 R5 R7 tick", tick_of(c), e_tick[c]);
            check("R6 R7 overflow", int'(rec_ovf_o[c]), e_ovf[c]);
         end
      end
   end

   // One step: toggle input ch at loop cycles t1 and t2 (-1 = none), extra random
   // toggles when rnd is set, strobe on the last cycle, then one idle cycle.
   task automatic run_step(input int len, input int ch, input int t1, input int t2, input bit rnd);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (i == t1 || i == t2) raw_i[ch] = ~raw_i[ch];
         if (rnd && ($urandom_range(0, 7) == 0)) raw_i[$urandom_range(0, N-1)] ^= 1'b1;
         step_i = (i == len-1);
      end
      @(negedge clk);
      step_i = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: outputs cleared during reset
      check("R11 reset valid", int'(rec_valid_o), 0);
      check("R11 reset chg", int'(rec_chg_o), 0);
      check("R11 reset tick", int'(rec_tick_o), 0);
      check("R11 reset levels", int'({rec_old_o, rec_new_o, rec_ovf_o}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      live = 1'b1;

      run_step(20, 0, -1, -1, 0);
      check("R7 quiet step tick", tick_of(0), 0);

      run_step(20, 0, 5, -1, 0);
      check("R2 single edge index", tick_of(0), 7);
      check("R4 single edge changed", int'(rec_chg_o[0]), 1);

      run_step(20, 1, 3, 9, 0);
      check("R6 second edge overflow", int'(rec_ovf_o[1]), 1);
      check("R5 first index kept", tick_of(1), 5);
      check("R3 returned level", int'(rec_new_o[1] == rec_old_o[1]), 1);

      run_step(20, 2, 17, -1, 0);
      check("R10 strobe-cycle edge in closing step", int'(rec_chg_o[2]), 1);
      check("R10 strobe-cycle index", tick_of(2), 19);
      run_step(20, 2, -1, -1, 0);
      check("R10 not repeated next step", int'(rec_chg_o[2]), 0);

      run_step(50, 3, 45, -1, 0);
      check("R2 saturated index", tick_of(3), MAXT - SYNC);

      os_en_i = 1'b0;
      run_step(20, 0, 4, 8, 0);
      check("R9 disabled double toggle", int'(rec_chg_o[0]), 0);
      run_step(20, 3, 6, -1, 0);
      check("R9 disabled single toggle", int'(rec_chg_o[3]), 1);
      check("R9 disabled tick", tick_of(3), 0);
      os_en_i = 1'b1;

      for (int k = 0; k < 40; k++)
         run_step($urandom_range(6, 40), $urandom_range(0, N-1), $urandom_range(0, 5), -1, 1);
      for (int k = 0; k < 10; k++)
         run_step(3, 0, 0, -1, 1);

      live = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule